// File: doc/BRIEF.md
# Armed Edge Capture Interrupt Bank

This block watches a bank of input channels (32 by default) for a selected edge and records each hit in a sticky capture flag. A channel records a hit only while it is armed. Each channel also has an interrupt enable. A capture on an enabled channel sets that channel's interrupt flag. All interrupt flags are ORed together, gated by a global enable, and driven out on one registered request line.

Software reaches the block through a simple word-wide write port and read port. Each register sits at a 3-bit word index:

| Index | Register | Access |
|-------|----------|--------|
| 0 | edge polarity | read/write |
| 1 | arm control | write: masked set or clear; read: the arm state |
| 2 | interrupt enable | read/write |
| 3 | control: bit 0 is the global enable, bit 1 is the arm mode | read/write |
| 4 | capture flags | read-only |
| 5 | interrupt flags | read-only |
| 6 | synchronised input levels | read-only |

The arm state cannot be loaded directly. A write to the arm control index sets or clears only the bits written as 1, and the stored arm mode decides which of the two happens. Disarming a channel is the only way to clear its capture and interrupt flags.

Top module: `edge_capture_bank`

## Requirements
- R1: Edge polarity bit i = 0 makes channel i detect a rising edge; bit i = 1 makes it detect a falling edge. The opposite edge is not recorded.
- R2: A write to index 1 while the arm mode (control bit 1) is 1 arms each channel whose data bit is 1. Channels written with 0 keep their arm state.
- R3: A write to index 1 while the arm mode is 0 disarms each channel whose data bit is 1. Channels written with 0 keep their arm state. A read of index 1 returns the arm state, with 1 meaning armed.
- R4: The capture flag of a channel is set when its selected edge is detected on its synchronised input while the channel is armed. An unarmed channel records nothing.
- R5: A capture flag stays set through further edges and through re-arming, and it is cleared only by disarming its channel.
- R6: When a capture event occurs while the channel's interrupt enable (index 2) is 1, the channel's interrupt flag is set. Disarming clears the flag. A channel whose enable is 0 sets no interrupt flag.
- R7: The request output equals, one cycle later, the global enable (control bit 0) ANDed with the OR of all interrupt flags. It is 0 whenever the global enable is 0.
- R8: After reset, every register, the arm state, all flags and the request output read 0.
- R9: If a disarm write and a detected edge fall on the same channel in the same cycle, the disarm wins and the capture and interrupt flags end at 0.
- R10: An edge detected in the same cycle as the write that arms its channel is not captured.
- R11: Writes to indices 4, 5 and 6 have no effect on the flags.
- R12: A read returns, in the cycle after the read strobe, the addressed word. Index 6 returns the input levels after a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word index |
| wr_data | input | NCH | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read word index |
| rd_data | output | NCH | Registered read data |
| chan_in | input | NCH | Asynchronous channel inputs |
| irq | output | 1 | Registered combined interrupt request |

## Verification
Two functions can meet in one cycle: an edge reaching the detector, and a software write to the arm control index for the same channel. The bench changes an input and then issues the arm-control write exactly two clock edges later. That is the cycle in which the detector sees the change. It does this once with a disarm write, where the flags must read back as 0, and once with an arm write, where the arm bit must read 1 and the capture flag 0.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_EDGE  = 3'd0,
    A_ARM   = 3'd1,
    A_IEN   = 3'd2,
    A_CTRL  = 3'd3,
    A_CAPT  = 3'd4,
    A_IFLG  = 3'd5,
    A_LEVEL = 3'd6
  } ecb_addr_e;

  localparam int CTRL_GIE_BIT  = 0;
  localparam int CTRL_MODE_BIT = 1;
endpackage

// File: rtl/ecb_edge_detect.sv
module ecb_edge_detect #(
  parameter int NCH    = 32,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin_i,
  input  logic [NCH-1:0] sel_i,
  output logic [NCH-1:0] level_o,
  output logic [NCH-1:0] hit_o
);
  localparam int LAST = STAGES - 1;

  logic [NCH-1:0] chain [STAGES];
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] rise, fall;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain[LAST];
  end

  assign level_o = chain[LAST];
  assign rise    = chain[LAST] & ~prev_q;
  assign fall    = ~chain[LAST] & prev_q;
  assign hit_o   = (sel_i & fall) | (~sel_i & rise);

  // R1: a hit always reflects a change between the last two samples
  a_r1_hit_is_change: assert property (@(posedge clk) disable iff (rst)
    (|hit_o) |-> ((chain[LAST] ^ prev_q) != '0));
endmodule

// File: rtl/ecb_regs.sv
module ecb_regs
  import ecb_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NCH-1:0]    wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NCH-1:0]    arm_i,
  input  logic [NCH-1:0]    cap_i,
  input  logic [NCH-1:0]    iflg_i,
  input  logic [NCH-1:0]    level_i,
  output logic [NCH-1:0]    edge_sel_o,
  output logic [NCH-1:0]    ien_o,
  output logic              gie_o,
  output logic [NCH-1:0]    arm_set_o,
  output logic [NCH-1:0]    arm_clr_o,
  output logic [NCH-1:0]    rd_data_o
);
  logic           mode_q;
  logic           arm_wr;
  logic [NCH-1:0] ctrl_word;
  logic [NCH-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_sel_o <= '0;
      ien_o      <= '0;
      gie_o      <= 1'b0;
      mode_q     <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_EDGE: edge_sel_o <= wr_data;
        A_IEN:  ien_o      <= wr_data;
        A_CTRL: begin
          gie_o  <= wr_data[CTRL_GIE_BIT];
          mode_q <= wr_data[CTRL_MODE_BIT];
        end
        default: ;
      endcase
    end
  end

  assign arm_wr    = wr_en && (wr_addr == A_ARM);
  assign arm_set_o = (arm_wr &&  mode_q) ? wr_data : '0;
  assign arm_clr_o = (arm_wr && !mode_q) ? wr_data : '0;

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_GIE_BIT]  = gie_o;
    ctrl_word[CTRL_MODE_BIT] = mode_q;
  end

  always_comb begin
    case (rd_addr)
      A_EDGE:  rd_next = edge_sel_o;
      A_ARM:   rd_next = arm_i;
      A_IEN:   rd_next = ien_o;
      A_CTRL:  rd_next = ctrl_word;
      A_CAPT:  rd_next = cap_i;
      A_IFLG:  rd_next = iflg_i;
      A_LEVEL: rd_next = level_i;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data_o <= '0;
    else if (rd_en) rd_data_o <= rd_next;
  end

  // R2/R3: set and clear masks never fire together
  a_r3_masks_exclusive: assert property (@(posedge clk) disable iff (rst)
    ((arm_set_o & arm_clr_o) == '0));
endmodule

// File: rtl/ecb_chan_array.sv
module ecb_chan_array #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] hit_i,
  input  logic [NCH-1:0] ien_i,
  input  logic [NCH-1:0] arm_set_i,
  input  logic [NCH-1:0] arm_clr_i,
  output logic [NCH-1:0] arm_o,
  output logic [NCH-1:0] cap_o,
  output logic [NCH-1:0] iflg_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic event_w;
    assign event_w = hit_i[i] & arm_o[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        arm_o[i]  <= 1'b0;
        cap_o[i]  <= 1'b0;
        iflg_o[i] <= 1'b0;
      end else begin
        if (arm_clr_i[i])      arm_o[i] <= 1'b0;
        else if (arm_set_i[i]) arm_o[i] <= 1'b1;

        // disarm beats a simultaneous edge
        if (arm_clr_i[i])  cap_o[i] <= 1'b0;
        else if (event_w)  cap_o[i] <= 1'b1;

        if (arm_clr_i[i])              iflg_o[i] <= 1'b0;
        else if (event_w && ien_i[i])  iflg_o[i] <= 1'b1;
      end
    end

    a_r2_set_arms: assert property (@(posedge clk) disable iff (rst)
      arm_set_i[i] |=> arm_o[i]);
    a_r5_disarm_clears: assert property (@(posedge clk) disable iff (rst)
      arm_clr_i[i] |=> (!arm_o[i] && !cap_o[i] && !iflg_o[i]));
    a_r4_capture_needs_arm: assert property (@(posedge clk) disable iff (rst)
      $rose(cap_o[i]) |-> ($past(arm_o[i]) && $past(hit_i[i])));
    a_r6_iflag_implies_cap: assert property (@(posedge clk) disable iff (rst)
      iflg_o[i] |-> cap_o[i]);
  end
endmodule

// File: rtl/edge_capture_bank.sv
module edge_capture_bank
  import ecb_pkg::*;
#(
  parameter int NCH       = 32,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NCH-1:0]    wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NCH-1:0]    rd_data,
  input  logic [NCH-1:0]    chan_in,
  output logic              irq
);
  logic [NCH-1:0] level_w, hit_w, edge_sel_w, ien_w;
  logic [NCH-1:0] arm_set_w, arm_clr_w, arm_w, cap_w, iflg_w;
  logic           gie_w;

  ecb_edge_detect #(.NCH(NCH), .STAGES(SYNC_STGS)) u_detect (
    .clk(clk), .rst(rst), .pin_i(chan_in), .sel_i(edge_sel_w),
    .level_o(level_w), .hit_o(hit_w)
  );

  ecb_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .arm_i(arm_w), .cap_i(cap_w), .iflg_i(iflg_w), .level_i(level_w),
    .edge_sel_o(edge_sel_w), .ien_o(ien_w), .gie_o(gie_w),
    .arm_set_o(arm_set_w), .arm_clr_o(arm_clr_w), .rd_data_o(rd_data)
  );

  ecb_chan_array #(.NCH(NCH)) u_chans (
    .clk(clk), .rst(rst), .hit_i(hit_w), .ien_i(ien_w),
    .arm_set_i(arm_set_w), .arm_clr_i(arm_clr_w),
    .arm_o(arm_w), .cap_o(cap_w), .iflg_o(iflg_w)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= gie_w & (|iflg_w);
  end

  a_r7_gie_blocks: assert property (@(posedge clk) disable iff (rst)
    !$past(gie_w) |-> !irq);
  a_r7_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|iflg_w));
endmodule

// File: tb/edge_capture_bank_bench.sv
module edge_capture_bank_bench;
  import ecb_pkg::*;
  localparam int NCH = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [NCH-1:0]    wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [NCH-1:0]    rd_data;
  logic [NCH-1:0]    chan_in = '0;
  logic              irq;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  edge_capture_bank #(.NCH(NCH)) u_edge_capture_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .chan_in(chan_in), .irq(irq)
  );

  task automatic check(input string req, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [NCH-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [NCH-1:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input int ch, input logic v);
    @(negedge clk); chan_in[ch] = v;
    idle(4);
  endtask

  task automatic disarm_all();
    wr(A_CTRL, 32'h0);
    wr(A_ARM, '1);
  endtask

  task automatic t_reset();
    logic [NCH-1:0] d;
    for (int a = 0; a < 7; a++) begin
      rd(a[ADDR_W-1:0], d);
      check("R8 reset register", d, '0);
    end
    check("R8 reset irq", {31'b0, irq}, '0);
  endtask

  task automatic t_arm_masks();
    logic [NCH-1:0] d;
    wr(A_CTRL, 32'h2);
    wr(A_ARM, 32'h0000_000D);
    rd(A_ARM, d); check("R2 arm 0,2,3", d, 32'h0000_000D);
    wr(A_ARM, 32'h0000_0040);
    rd(A_ARM, d); check("R2 arm adds 6", d, 32'h0000_004D);
    wr(A_CTRL, 32'h0);
    wr(A_ARM, 32'h0000_0009);
    rd(A_ARM, d); check("R3 disarm 0,3", d, 32'h0000_0044);
    rd(A_CTRL, d); check("R3 mode readback", d, 32'h0);
    disarm_all();
  endtask

  task automatic t_rising();
    logic [NCH-1:0] d;
    wr(A_EDGE, 32'h0);
    wr(A_CTRL, 32'h2);
    wr(A_ARM, 32'h0000_0004);
    set_pin(5, 1'b1);
    set_pin(2, 1'b1);
    rd(A_CAPT, d); check("R4 rising on armed ch2 only", d, 32'h0000_0004);
    rd(A_LEVEL, d); check("R12 level readback", d, 32'h0000_0024);
    set_pin(2, 1'b0); set_pin(5, 1'b0);
    disarm_all();
    rd(A_CAPT, d); check("R5 disarm clears", d, '0);
  endtask

  task automatic t_falling();
    logic [NCH-1:0] d;
    wr(A_EDGE, 32'h0000_0040);
    wr(A_CTRL, 32'h2);
    wr(A_ARM, 32'h0000_0040);
    set_pin(6, 1'b1);
    rd(A_CAPT, d); check("R1 rise ignored on falling select", d, '0);
    set_pin(6, 1'b0);
    rd(A_CAPT, d); check("R1 fall captured", d, 32'h0000_0040);
    set_pin(6, 1'b1); set_pin(6, 1'b0);
    wr(A_ARM, 32'h0000_0040);
    rd(A_CAPT, d); check("R5 sticky through edges and rearm", d, 32'h0000_0040);
    disarm_all();
    rd(A_CAPT, d); check("R5 cleared by disarm", d, '0);
    wr(A_EDGE, 32'h0);
  endtask

  task automatic t_irq();
    logic [NCH-1:0] d;
    wr(A_IEN, 32'h0000_0100);
    wr(A_CTRL, 32'h2);
    wr(A_ARM, 32'h0000_0300);
    set_pin(8, 1'b1); set_pin(9, 1'b1);
    rd(A_CAPT, d); check("R6 both captured", d, 32'h0000_0300);
    rd(A_IFLG, d); check("R6 only enabled flag", d, 32'h0000_0100);
    check("R7 gie off blocks irq", {31'b0, irq}, '0);
    wr(A_CTRL, 32'h3);
    idle(1);
    check("R7 irq asserted", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h1);
    wr(A_ARM, 32'h0000_0100);
    rd(A_IFLG, d); check("R6 disarm clears iflag", d, '0);
    check("R7 irq drops", {31'b0, irq}, '0);
    set_pin(8, 1'b0); set_pin(9, 1'b0);
    disarm_all();
    wr(A_IEN, 32'h0);
  endtask

  // edge reaches the detector in the cycle the arm-control write commits
  task automatic t_collide(input logic mode);
    logic [NCH-1:0] d;
    wr(A_CTRL, 32'h2);
    wr(A_ARM, mode ? 32'h0 : 32'h0000_0008);
    wr(A_IEN, 32'h0000_0008);
    wr(A_CTRL, {30'b0, mode, 1'b0});
    @(negedge clk); chan_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = A_ARM; wr_data = 32'h0000_0008;
    @(negedge clk); wr_en = 1'b0;
    idle(3);
    rd(A_CAPT, d);
    if (mode) check("R10 arm same cycle no capture", d, '0);
    else      check("R9 disarm wins capture", d, '0);
    rd(A_IFLG, d);
    check(mode ? "R10 no iflag" : "R9 disarm wins iflag", d, '0);
    rd(A_ARM, d);
    check(mode ? "R10 arm took effect" : "R9 disarmed", d, mode ? 32'h8 : 32'h0);
    set_pin(3, 1'b0);
    disarm_all();
    wr(A_IEN, 32'h0);
  endtask

  task automatic t_readonly();
    logic [NCH-1:0] d;
    wr(A_CTRL, 32'h2);
    wr(A_ARM, 32'h0000_0001);
    wr(A_IEN, 32'h0000_0001);
    set_pin(0, 1'b1);
    wr(A_CAPT, 32'h0);
    wr(A_IFLG, 32'h0);
    wr(A_LEVEL, 32'hFFFF_0000);
    rd(A_CAPT, d);  check("R11 capture kept", d, 32'h1);
    rd(A_IFLG, d);  check("R11 iflag kept", d, 32'h1);
    rd(A_LEVEL, d); check("R11 level unaffected", d, 32'h1);
    set_pin(0, 1'b0);
    disarm_all();
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_arm_masks();
    t_rising();
    t_falling();
    t_irq();
    t_collide(1'b0);
    t_collide(1'b1);
    t_readonly();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule